// File: doc/BRIEF.md
# Impedance Calibration Sequencer

This block runs an automatic strength calibration over four I/O segments: output-drive pull-down, output-drive pull-up, termination pull-down and termination pull-up. A single start pulse sets every segment's strength code to mid-scale and marks all four segments as pending. The block then works through them one at a time in that fixed order. Each cycle, it steps the active segment's code by one toward the target that the external comparator indicates. It stops when the comparator answer flips, or when the code would leave its range.

The result is a packed status word with a 2-bit state per segment, a sticky error flag, a done flag and four saturation flags. A saturation flag shows that a signed adjustment factor, added to a finished segment's code, falls outside the code range. The memory mode selects which saturation flags can be reported. Two copies are instantiated in a chip, one for the command/address group and one for the data group.

There is no data stream here, so there is no valid/ready handshake and no back-pressure. The start pulse, comparator bit, mode and adjustment inputs are plain levels sampled on every rising edge. The codes and the status word are registered levels, except the saturation bits, which follow the mode and adjustment inputs combinationally.

Top module: `zcal_seq`

## Requirements
- R1: After reset every segment code is mid-scale (32), every segment state is 11 (pending), and the error, done and saturation bits are 0. This gives status_o = 14'h00FF.
- R2: A cal_start pulse, sampled on any edge, takes effect at that edge, whether calibration is idle, running or finished. After that edge all codes read 32, all segment states read 11, and the error and done bits read 0.
- R3: Segments run one at a time in the order 0 (drive pull-down), 1 (drive pull-up), 2 (termination pull-down), 3 (termination pull-up). A segment's state leaves 11 only after the state of every earlier segment has left 11.
- R4: While a segment is active, its code rises by one on each edge where cmp_in is 1 and falls by one on each edge where cmp_in is 0.
- R5: On the first edge where cmp_in differs from the value it had on the segment's previous step, the segment's state becomes 00 (clean finish). Its code is left unchanged.
- R6: If cmp_in is 1 while the active code is 63, the segment's state becomes 01 (overflow) and its code stays at 63.
- R7: If cmp_in is 0 while the active code is 0, the segment's state becomes 10 (underflow) and its code stays at 0.
- R8: Error bit 8 is set on the edge at which any segment ends with state 01 or 10. It stays set until the next cal_start.
- R9: Done bit 9 is set on the edge at which segment 3 finishes. It stays set until the next cal_start.
- R10: status_o packs the segment states as [1:0] segment 0, [3:2] segment 1, [5:4] segment 2 and [7:6] segment 3. code_o packs the codes as [5:0] segment 0 up to [23:18] segment 3.
- R11: The adjustment factor for segment s is a 4-bit signed value in adj_i[4s+3:4s]. Once segment s has finished, a saturation condition exists when code + adjustment is below 0 or above 63. The flags are: bit 10 for segment 1, bit 11 for segment 0, bit 12 for segment 3 and bit 13 for segment 2.
- R12: Bits 11 and 12 can be 1 only when mode_sel = 2'b01. Bits 10 and 13 can be 1 only when mode_sel = 2'b10. With any other mode, all four saturation bits are 0.
- R13: After done is set, and until the next cal_start, the codes and status bits [9:0] do not change, whatever cmp_in does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Start or restart pulse |
| cmp_in | input | 1 | Comparator result for the active segment; 1 asks for a stronger (higher) code |
| mode_sel | input | 2 | Memory mode: 01 first mode, 10 second mode, others neither |
| adj_i | input | 16 | Four 4-bit signed adjustment factors, segment s at [4s+3:4s] |
| code_o | output | 24 | Four 6-bit strength codes, segment s at [6s+5:6s] |
| status_o | output | 14 | Packed segment states, error, done and saturation flags |

## Verification
The assertions assume that cal_start is a pulse driven only after reset is released. They also assume that cmp_in is meaningful only for the segment currently active, and that mode_sel and adj_i may change at any time. The saturation checks therefore tie the flags to the current mode and never to a past one. The stimulus holds reset from time zero and drives every input on the falling edge. It derives cmp_in from a model comparator: the active code is compared with a per-segment target, with the active segment taken as the first one whose state still reads 11 at the ports. The chosen targets reach both ends of the code range, a turn right next to mid-scale, and a restart in the middle of a run.

// File: rtl/zcal_pkg.sv
package zcal_pkg;
  typedef enum logic [1:0] {
    ST_OK   = 2'b00,
    ST_OVF  = 2'b01,
    ST_UNF  = 2'b10,
    ST_BUSY = 2'b11
  } seg_st_e;

  localparam int          NSEG      = 4;
  localparam logic [1:0]  MODE_DDR4 = 2'b01;
  localparam logic [1:0]  MODE_LP4  = 2'b10;
endpackage

// File: rtl/zcal_segment.sv
module zcal_segment
  import zcal_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              active,
  input  logic              cmp,
  output logic [CODE_W-1:0] code_o,
  output seg_st_e           st_o,
  output logic              fin_o,
  output logic              fin_err_o
);
  localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};

  logic    have_prev_q, prev_q;
  logic    turn, at_top, at_bot, evaluating;

  assign evaluating = active && (st_o == ST_BUSY);
  assign turn       = have_prev_q && (cmp != prev_q);
  assign at_top     = cmp && (code_o == MAXC);
  assign at_bot     = !cmp && (code_o == '0);
  assign fin_o      = evaluating && (turn || at_top || at_bot);
  assign fin_err_o  = evaluating && !turn && (at_top || at_bot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o      <= MID;
      st_o        <= ST_BUSY;
      have_prev_q <= 1'b0;
      prev_q      <= 1'b0;
    end else if (restart) begin
      code_o      <= MID;
      st_o        <= ST_BUSY;
      have_prev_q <= 1'b0;
      prev_q      <= 1'b0;
    end else if (evaluating) begin
      if (turn)        st_o <= ST_OK;
      else if (at_top) st_o <= ST_OVF;
      else if (at_bot) st_o <= ST_UNF;
      else begin
        code_o      <= cmp ? code_o + CODE_W'(1) : code_o - CODE_W'(1);
        prev_q      <= cmp;
        have_prev_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/zcal_sat.sv
module zcal_sat
  import zcal_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int ADJ_W  = 4
) (
  input  logic [NSEG*CODE_W-1:0] codes_i,
  input  logic [NSEG*2-1:0]      st_i,
  input  logic [NSEG*ADJ_W-1:0]  adj_i,
  input  logic [1:0]             mode_i,
  output logic [3:0]             sat_o
);
  localparam int SW = CODE_W + 2;

  logic [NSEG-1:0] oor;

  for (genvar s = 0; s < NSEG; s++) begin : g_scale
    logic [ADJ_W-1:0] a;
    logic [SW-1:0]    scaled;
    assign a      = adj_i[s*ADJ_W +: ADJ_W];
    assign scaled = {2'b00, codes_i[s*CODE_W +: CODE_W]}
                  + {{(SW-ADJ_W){a[ADJ_W-1]}}, a};
    // below zero sets the sign bit, above the maximum sets the next bit
    assign oor[s] = (st_i[s*2 +: 2] != ST_BUSY) && (scaled[SW-1] || scaled[SW-2]);
  end

  logic ddr4_en, lp4_en;
  assign ddr4_en = (mode_i == MODE_DDR4);
  assign lp4_en  = (mode_i == MODE_LP4);

  assign sat_o[0] = oor[1] && lp4_en;   // drive pull-up
  assign sat_o[1] = oor[0] && ddr4_en;  // drive pull-down
  assign sat_o[2] = oor[3] && ddr4_en;  // termination pull-up
  assign sat_o[3] = oor[2] && lp4_en;   // termination pull-down
endmodule

// File: rtl/zcal_seq.sv
module zcal_seq
  import zcal_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int ADJ_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cal_start,
  input  logic                   cmp_in,
  input  logic [1:0]             mode_sel,
  input  logic [NSEG*ADJ_W-1:0]  adj_i,
  output logic [NSEG*CODE_W-1:0] code_o,
  output logic [13:0]            status_o
);
  localparam int IDX_W = $clog2(NSEG);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSEG - 1);

  logic             busy_q, done_q, err_q;
  logic [IDX_W-1:0] act_q;
  logic [NSEG-1:0]  fin, fin_err;
  logic [NSEG*2-1:0] st_flat;
  logic [3:0]       sat;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    seg_st_e st;
    logic    act;
    assign act = busy_q && (act_q == IDX_W'(s));
    zcal_segment #(.CODE_W(CODE_W)) u_seg (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (cal_start),
      .active    (act),
      .cmp       (cmp_in),
      .code_o    (code_o[s*CODE_W +: CODE_W]),
      .st_o      (st),
      .fin_o     (fin[s]),
      .fin_err_o (fin_err[s])
    );
    assign st_flat[s*2 +: 2] = st;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (cal_start) begin
      busy_q <= 1'b1;
      act_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (busy_q) begin
      if (|fin_err) err_q <= 1'b1;
      if (|fin) begin
        if (act_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          act_q <= act_q + IDX_W'(1);
        end
      end
    end
  end

  zcal_sat #(.CODE_W(CODE_W), .ADJ_W(ADJ_W)) u_sat (
    .codes_i (code_o),
    .st_i    (st_flat),
    .adj_i   (adj_i),
    .mode_i  (mode_sel),
    .sat_o   (sat)
  );

  assign status_o = {sat, done_q, err_q, st_flat};
endmodule

// File: rtl/zcal_seq_chk.sv
module zcal_seq_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_start,
  input logic [1:0]        mode_sel,
  input logic [4*CODE_W-1:0] code_o,
  input logic [13:0]       status_o
);
  logic any_bad;
  assign any_bad = (status_o[1:0] == 2'b01) || (status_o[1:0] == 2'b10)
                || (status_o[3:2] == 2'b01) || (status_o[3:2] == 2'b10)
                || (status_o[5:4] == 2'b01) || (status_o[5:4] == 2'b10)
                || (status_o[7:6] == 2'b01) || (status_o[7:6] == 2'b10);

  for (genvar k = 1; k < 4; k++) begin : g_order
    p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[k*2 +: 2] != 2'b11) |-> (status_o[(k-1)*2 +: 2] != 2'b11));
  end

  for (genvar s = 0; s < 4; s++) begin : g_step
    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_start |=> (code_o[s*CODE_W +: CODE_W] == $past(code_o[s*CODE_W +: CODE_W])
                   || code_o[s*CODE_W +: CODE_W] == $past(code_o[s*CODE_W +: CODE_W]) + CODE_W'(1)
                   || code_o[s*CODE_W +: CODE_W] == $past(code_o[s*CODE_W +: CODE_W]) - CODE_W'(1)));
  end

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (!status_o[9] && !status_o[8] && status_o[7:0] == 8'hFF));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[9] |-> (status_o[8] == any_bad));

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[9] && !cal_start) |=> ($stable(code_o) && $stable(status_o[9:0])));

  p_gate_ddr4_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b01) |-> (!status_o[11] && !status_o[12]));

  p_gate_lp4_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b10) |-> (!status_o[10] && !status_o[13]));
endmodule

bind zcal_seq zcal_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cal_start (cal_start),
  .mode_sel  (mode_sel),
  .code_o    (code_o),
  .status_o  (status_o)
);

// File: tb/zcal_seq_tb_top.sv
`timescale 1ns/1ps
module zcal_seq_tb_top;
  typedef struct {
    logic [23:0] codes;
    logic [13:0] status;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_start = 1'b0;
  logic        cmp_in = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [15:0] adj_i = '0;
  logic [23:0] code_o;
  logic [13:0] status_o;

  int   n_chk = 0;
  int   n_fail = 0;
  int   tgt [4];
  exp_t exp_q [$];

  always #2.5 clk = ~clk;

  zcal_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .cmp_in(cmp_in),
    .mode_sel(mode_sel), .adj_i(adj_i), .code_o(code_o), .status_o(status_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int t);
    if (t > 32) return (t > 63) ? 63 : t;
    return (t == 0) ? 0 : t - 1;
  endfunction

  function automatic logic [1:0] exp_st(input int t);
    if (t > 63) return 2'b01;
    if (t == 0) return 2'b10;
    return 2'b00;
  endfunction

  function automatic exp_t predict(input logic [1:0] mode, input logic [15:0] adj);
    exp_t e;
    logic [3:0] oor;
    logic err;
    err = 1'b0;
    for (int s = 0; s < 4; s++) begin
      int sc;
      e.codes[s*6 +: 6]  = 6'(exp_code(tgt[s]));
      e.status[s*2 +: 2] = exp_st(tgt[s]);
      if (exp_st(tgt[s]) != 2'b00) err = 1'b1;
      sc = exp_code(tgt[s]) + int'($signed(adj[s*4 +: 4]));
      oor[s] = (sc < 0) || (sc > 63);
    end
    e.status[8]  = err;
    e.status[9]  = 1'b1;
    e.status[10] = oor[1] && (mode == 2'b10);
    e.status[11] = oor[0] && (mode == 2'b01);
    e.status[12] = oor[3] && (mode == 2'b01);
    e.status[13] = oor[2] && (mode == 2'b10);
    return e;
  endfunction

  // start pulse, then model the comparator until every segment has left 11
  task automatic run_cal(input logic [1:0] mode, input logic [15:0] adj, input logic step_chk);
    mode_sel = mode;
    adj_i    = adj;
    exp_q.push_back(predict(mode, adj));
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    chk(status_o[9:0] == 10'h0FF, "R2 restart state", status_o, 14'h00FF);
    chk(code_o == {4{6'd32}}, "R2 restart codes", code_o, {4{6'd32}});
    for (int i = 1; i < 400; i++) begin
      int act;
      act = -1;
      for (int s = 3; s >= 0; s--) if (status_o[s*2 +: 2] == 2'b11) act = s;
      if (act < 0) break;
      if (step_chk && i == 4)
        chk(code_o[5:0] == 6'd35, "R4 step by one", code_o[5:0], 35);
      cmp_in = (int'(code_o[act*6 +: 6]) < tgt[act]);
      @(negedge clk);
    end
  endtask

  // monitor: compare on every rise of done
  initial begin
    logic done_prev;
    done_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && status_o[9] && !done_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected done", status_o, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(code_o == e.codes, "R5 R6 R7 final codes", code_o, e.codes);
          chk(status_o[7:0] == e.status[7:0], "R3 R10 segment states", status_o[7:0], e.status[7:0]);
          chk(status_o[8] == e.status[8], "R8 error flag", status_o[8], e.status[8]);
          chk(status_o[13:10] == e.status[13:10], "R11 R12 saturation", status_o[13:10], e.status[13:10]);
        end
      end
      done_prev = status_o[9];
    end
  end

  initial begin
    logic [23:0] hold_c;
    logic [9:0]  hold_s;
    repeat (4) @(negedge clk);
    chk(status_o == 14'h00FF, "R1 reset status", status_o, 14'h00FF);
    chk(code_o == {4{6'd32}}, "R1 reset codes", code_o, {4{6'd32}});
    rst_n = 1'b1;
    @(negedge clk);

    // clean finishes on both sides of mid-scale
    tgt = '{40, 20, 33, 32};
    run_cal(2'b01, 16'h0000, 1'b1);
    chk(status_o[9] == 1'b1, "R9 done set", status_o[9], 1);

    // range ends, second mode: drive pull-up saturates below zero
    tgt = '{64, 0, 45, 10};
    run_cal(2'b10, 16'h00F1, 1'b0);
    chk(code_o[5:0] == 6'd63, "R6 held at top", code_o[5:0], 63);
    chk(code_o[11:6] == 6'd0, "R7 held at bottom", code_o[11:6], 0);

    // same codes, first mode: drive pull-down flag instead
    run_cal(2'b01, 16'h00F1, 1'b0);
    mode_sel = 2'b11;
    @(negedge clk);
    chk(status_o[13:10] == 4'h0, "R12 other mode gates", status_o[13:10], 0);

    // restart in the middle of a run
    mode_sel = 2'b00;
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    cmp_in = 1'b1;
    repeat (5) @(negedge clk);
    tgt = '{50, 12, 60, 3};
    run_cal(2'b00, 16'h7777, 1'b0);

    // hold after done
    hold_c = code_o;
    hold_s = status_o[9:0];
    for (int i = 0; i < 8; i++) begin
      cmp_in = ~cmp_in;
      @(negedge clk);
    end
    chk(code_o == hold_c, "R13 codes held", code_o, hold_c);
    chk(status_o[9:0] == hold_s, "R13 status held", status_o[9:0], hold_s);
    chk(exp_q.size() == 0, "R9 all results seen", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule